// File: doc/BRIEF.md
# Codec Register Initialization Sequencer

This block brings an audio codec out of reset by writing a fixed list of ten configuration words to it over a two-wire serial control bus. It is the bus master and the only one on the bus. After a one-cycle `start` pulse it sends each word as a separate write transfer. A transfer opens with a START condition and carries three bytes: the device address with the write flag, then the upper byte of the word, then the lower byte. A STOP condition closes it. Each word holds a 7-bit register address followed by a 9-bit register value. Splitting it at byte boundaries therefore puts the register address plus value bit 8 in the second byte and value bits 7..0 in the third.

The block drives the clock line `scl` directly. The data line is open-drain: `sda_low` high means the block pulls the line to 0, and `sda_low` low means it releases the line. The resolved line level comes back on `sda_i`. Bus timing is paced by an internal tick. Its divider is derived from the system clock frequency so that `scl` never exceeds the codec's 526 kHz limit. If the codec fails to acknowledge a byte, the block closes the transfer with a STOP, raises `ack_err` and sends the same word again. After the tenth word, the one that activates the codec, `done` rises and stays high until reset.

The control pins are plain level and pulse signals. The block has no streaming data interface, so no valid/ready handshake or back-pressure applies.

Top module: `codec_init_seq`

## Requirements
- R1: After reset, `scl` is 1, `sda_low` is 0 (line released), and `done` and `ack_err` are 0. With no `start` pulse the bus stays idle.
- R2: A one-cycle `start` pulse while idle begins the sequence. A `start` pulse while a sequence is running or after `done` has no effect on the bus.
- R3: Each transfer begins with a START condition: the data line falls while `scl` is high.
- R4: Outside START and STOP conditions, the data line changes only while `scl` is low. Every byte is sent most-significant bit first.
- R5: Each transfer ends with a STOP condition: the data line rises while `scl` is high. The bus is then left idle, with `scl` high and the line released.
- R6: During the ninth (acknowledge) bit of every byte the block releases the data line and samples it while `scl` is high.
- R7: A transfer carries the bytes 0x34 (address 0011010 followed by write flag 0), then word bits 15..8, then word bits 7..0.
- R8: The words are written in the order 0x0097, 0x0297, 0x0479, 0x0679, 0x0815, 0x0A00, 0x0C00, 0x0E42, 0x1019, 0x1201, with the activate word 0x1201 last.
- R9: One bit takes 4 ticks and each START or STOP takes 3 ticks. The tick divider is ceil(CLK_HZ / (4 * SCL_MAX_HZ)), so successive `scl` rising edges are at least 4 * divider clock cycles apart.
- R10: A 1 read on the data line during an acknowledge bit ends the transfer with a STOP and sets `ack_err`, which stays high until reset. The same word is then retried.
- R11: `done` rises only after the last word has been acknowledged and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the sequence |
| sda_i | input | 1 | Resolved level of the serial data line |
| scl | output | 1 | Serial clock line |
| sda_low | output | 1 | 1 pulls the data line low, 0 releases it |
| done | output | 1 | All words written; stays high until reset |
| ack_err | output | 1 | A missing acknowledge was seen; stays high until reset |

## Verification
The embedded assertions check on every cycle that the idle bus has `scl` high with the line released, and that the data line moves during high `scl` only in START and STOP phases. They also check that the line is released for the whole acknowledge bit, that `done` and `ack_err` never fall, and that a missed acknowledge leaves the word index unchanged. Only the bench scenarios can show the actual byte contents and their order across all ten transfers, the minimum `scl` period, the retry after an injected missing acknowledge, and that a late `start` pulse is ignored. For this the bench uses a behavioural codec model that decodes START, STOP, data bits and acknowledges from the bus.

// File: rtl/codec_init_pkg.sv
`timescale 1ns/1ps
package codec_init_pkg;
  localparam int WORD_W    = 16;
  localparam int N_WORDS   = 10;
  localparam int IDX_W     = $clog2(N_WORDS);
  localparam logic [6:0] CODEC_ADDR = 7'b0011010;

  typedef enum logic [1:0] {E_IDLE, E_START, E_BITS, E_STOP} eng_st_t;
  typedef enum logic [1:0] {T_IDLE, T_ISSUE, T_WAIT, T_DONE} seq_st_t;

  // Configuration words: {register address[6:0], value[8:0]}; activate last.
  function automatic logic [WORD_W-1:0] cfg_word(input logic [IDX_W-1:0] i);
    case (i)
      4'd0:    return 16'h0097;
      4'd1:    return 16'h0297;
      4'd2:    return 16'h0479;
      4'd3:    return 16'h0679;
      4'd4:    return 16'h0815;
      4'd5:    return 16'h0A00;
      4'd6:    return 16'h0C00;
      4'd7:    return 16'h0E42;
      4'd8:    return 16'h1019;
      default: return 16'h1201;
    endcase
  endfunction
endpackage

// File: rtl/codec_tick_gen.sv
`timescale 1ns/1ps
module codec_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = rst_n;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (cnt == CW'(DIV - 1)) cnt <= '0;
        else                         cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(DIV - 1));

      // R9: ticks are never back to back when the divider exceeds one
      p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/codec_word_rom.sv
`timescale 1ns/1ps
module codec_word_rom
  import codec_init_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] word
);
  always_comb word = cfg_word(idx);
endmodule

// File: rtl/i2c_write_engine.sv
`timescale 1ns/1ps
module i2c_write_engine
  import codec_init_pkg::*;
#(
  parameter int DATA_BYTES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    go,
  input  logic [6:0]              dev_addr,
  input  logic [8*DATA_BYTES-1:0] payload,
  input  logic                    sda_i,
  output logic                    scl_o,
  output logic                    sda_low_o,
  output logic                    fin_o,
  output logic                    nack_o
);
  localparam int NBYTES = DATA_BYTES + 1;
  localparam int FW     = 8 * NBYTES;
  localparam int BW     = $clog2(NBYTES + 1);

  eng_st_t        st;
  logic [1:0]     phase;
  logic [3:0]     bit_idx;
  logic [BW-1:0]  byte_idx;
  logic [FW-1:0]  frame_q;
  logic           nack_seen;
  logic           scl_q, sda_low_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= E_IDLE;
      phase     <= '0;
      bit_idx   <= '0;
      byte_idx  <= '0;
      frame_q   <= '0;
      nack_seen <= 1'b0;
      scl_q     <= 1'b1;
      sda_low_q <= 1'b0;
      fin_o     <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      case (st)
        E_IDLE: begin
          scl_q     <= 1'b1;
          sda_low_q <= 1'b0;
          if (go) begin
            frame_q   <= {dev_addr, 1'b0, payload};
            nack_seen <= 1'b0;
            phase     <= '0;
            st        <= E_START;
          end
        end
        E_START: if (tick) begin
          case (phase)
            2'd0: begin scl_q <= 1'b1; sda_low_q <= 1'b0; phase <= 2'd1; end
            2'd1: begin sda_low_q <= 1'b1; phase <= 2'd2; end
            default: begin
              scl_q    <= 1'b0;
              phase    <= '0;
              bit_idx  <= '0;
              byte_idx <= '0;
              st       <= E_BITS;
            end
          endcase
        end
        E_BITS: if (tick) begin
          case (phase)
            2'd0: begin
              sda_low_q <= (bit_idx == 4'd8) ? 1'b0 : ~frame_q[FW-1];
              phase     <= 2'd1;
            end
            2'd1: begin scl_q <= 1'b1; phase <= 2'd2; end
            2'd2: begin
              if (bit_idx == 4'd8 && sda_i) nack_seen <= 1'b1;
              phase <= 2'd3;
            end
            default: begin
              scl_q <= 1'b0;
              phase <= '0;
              if (bit_idx == 4'd8) begin
                bit_idx <= '0;
                if (nack_seen || byte_idx == BW'(NBYTES - 1)) st <= E_STOP;
                else byte_idx <= byte_idx + 1'b1;
              end else begin
                bit_idx <= bit_idx + 1'b1;
                frame_q <= {frame_q[FW-2:0], 1'b0};
              end
            end
          endcase
        end
        default: if (tick) begin
          case (phase)
            2'd0: begin sda_low_q <= 1'b1; phase <= 2'd1; end
            2'd1: begin scl_q <= 1'b1; phase <= 2'd2; end
            default: begin
              sda_low_q <= 1'b0;
              phase     <= '0;
              fin_o     <= 1'b1;
              st        <= E_IDLE;
            end
          endcase
        end
      endcase
    end
  end

  assign scl_o     = scl_q;
  assign sda_low_o = sda_low_q;
  assign nack_o    = nack_seen;

  // R4: data line moves under a high clock only for START or STOP
  p_sda_stable_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_q) && scl_q && !$stable(sda_low_q))
      |-> ($past(st) == E_START || $past(st) == E_STOP));
  // R6: line released for the whole acknowledge bit
  p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_BITS && bit_idx == 4'd8 && phase != 2'd0) |-> !sda_low_q);
  // R5: idle bus has clock high and data released
  p_idle_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_IDLE) |-> (scl_q && !sda_low_q));
  // R3: leaving START the line is held low
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == E_START && st == E_BITS) |-> sda_low_q);
endmodule

// File: rtl/codec_init_seq.sv
`timescale 1ns/1ps
module codec_init_seq
  import codec_init_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int SCL_MAX_HZ = 526_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sda_i,
  output logic scl,
  output logic sda_low,
  output logic done,
  output logic ack_err
);
  localparam int TICK_HZ  = 4 * SCL_MAX_HZ;
  localparam int TICK_DIV = (CLK_HZ + TICK_HZ - 1) / TICK_HZ;

  logic              tick;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] word;
  logic              go, eng_fin, eng_nack;
  seq_st_t           st;
  logic              done_q, err_q;

  codec_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  codec_word_rom u_rom (.idx(idx_q), .word(word));

  i2c_write_engine #(.DATA_BYTES(WORD_W / 8)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go),
    .dev_addr(CODEC_ADDR), .payload(word), .sda_i(sda_i),
    .scl_o(scl), .sda_low_o(sda_low), .fin_o(eng_fin), .nack_o(eng_nack));

  assign go = (st == T_ISSUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= T_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        T_IDLE:  if (start) st <= T_ISSUE;
        T_ISSUE: st <= T_WAIT;
        T_WAIT: if (eng_fin) begin
          if (eng_nack) begin
            err_q <= 1'b1;
            st    <= T_ISSUE;
          end else if (idx_q == IDX_W'(N_WORDS - 1)) begin
            done_q <= 1'b1;
            st     <= T_DONE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st    <= T_ISSUE;
          end
        end
        default: st <= T_DONE;
      endcase
    end
  end

  assign done    = done_q;
  assign ack_err = err_q;

  // R11: done never falls once raised
  p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // R11: done rises only when the last word was written
  p_done_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(idx_q) == IDX_W'(N_WORDS - 1) && $past(eng_fin)));
  // R10: error flag is sticky
  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |=> ack_err);
  // R10: a refused transfer retries the same word
  p_retry_same_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == T_WAIT && eng_fin && eng_nack) |=> ($stable(idx_q) && ack_err));
endmodule

// File: tb/test_codec_init_seq.sv
`timescale 1ns/1ps
module test_codec_init_seq;
  localparam int CLK_HZ = 4_208_000;
  localparam int SMAX   = 526_000;
  localparam int DIV    = (CLK_HZ + 4 * SMAX - 1) / (4 * SMAX);
  localparam int MAXF   = 16;

  // expected bytes per transfer: {address byte, word[15:8], word[7:0]}
  localparam logic [23:0] VEC [10] = '{
    24'h340097, 24'h340297, 24'h340479, 24'h340679, 24'h340815,
    24'h340A00, 24'h340C00, 24'h340E42, 24'h341019, 24'h341201};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic scl, sda_low, done, ack_err;
  logic slave_low = 1'b0;
  wire  bus = !(sda_low | slave_low);

  always #2 clk = ~clk;

  codec_init_seq #(.CLK_HZ(CLK_HZ), .SCL_MAX_HZ(SMAX)) i_codec_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sda_i(bus),
    .scl(scl), .sda_low(sda_low), .done(done), .ack_err(ack_err));

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural codec model, evaluated away from the active edge
  logic [7:0] fr_b [MAXF][3];
  int  fr_n [MAXF];
  int  frames = 0, starts = 0, stops = 0, bitc = 0, bytec = 0;
  int  cyc = 0, last_rise = -1, min_per = 1 << 30;
  bit  in_fr = 0, pscl = 1, psda = 1, inject = 0;
  int  nack_frame = 3;
  logic [7:0] sh = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      frames = 0; starts = 0; stops = 0; in_fr = 0; bitc = 0; bytec = 0;
      slave_low = 1'b0; last_rise = -1; min_per = 1 << 30;
      for (int i = 0; i < MAXF; i++) fr_n[i] = 0;
    end else begin
      if (scl && pscl && psda && !bus) begin
        in_fr = 1; bitc = 0; bytec = 0; starts++;
      end else if (scl && pscl && !psda && bus) begin
        in_fr = 0;
        if (frames < MAXF) fr_n[frames] = bytec;
        frames++; stops++;
      end else if (in_fr && scl && !pscl) begin
        if (last_rise >= 0 && cyc - last_rise < min_per) min_per = cyc - last_rise;
        last_rise = cyc;
        if (bitc < 8) sh = {sh[6:0], bus};
        bitc++;
        if (bitc == 8) begin
          if (frames < MAXF && bytec < 3) fr_b[frames][bytec] = sh;
          bytec++;
        end
      end else if (in_fr && !scl && pscl) begin
        if (bitc == 8) slave_low = !(inject && frames == nack_frame && bytec == 1);
        else if (bitc == 9) begin slave_low = 1'b0; bitc = 0; end
      end
      pscl = scl; psda = bus;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  bit ok;
  int f0;
  bit hung = 0;

  initial begin
    fork
      begin : wd
        repeat (150000) @(posedge clk);
        hung = 1;
      end
    join_none

    // R1 reset state
    do_reset();
    @(negedge clk);
    chk(scl == 1'b1, "R1 scl idle", scl, 1);
    chk(sda_low == 1'b0, "R1 sda released", sda_low, 0);
    chk(done == 1'b0, "R1 done low", done, 0);
    chk(ack_err == 1'b0, "R1 err low", ack_err, 0);
    repeat (100) @(negedge clk);
    chk(starts == 0 && scl, "R1 idle without start", starts, 0);

    // session 1: clean run
    pulse_start();
    wait_done(ok);
    chk(ok, "R11 done reached", ok, 1);
    repeat (20) @(negedge clk);
    chk(frames == 10, "R8 transfer count", frames, 10);
    chk(starts == 10, "R3 start count", starts, 10);
    chk(stops == 10, "R5 stop count", stops, 10);
    for (int k = 0; k < 10; k++) begin
      chk(fr_n[k] == 3, "R7 bytes per transfer", fr_n[k], 3);
      chk({fr_b[k][0], fr_b[k][1], fr_b[k][2]} == VEC[k],
          "R7 R8 R4 transfer bytes", {fr_b[k][0], fr_b[k][1], fr_b[k][2]}, VEC[k]);
    end
    chk(min_per >= 4 * DIV, "R9 scl period", min_per, 4 * DIV);
    chk(ack_err == 1'b0, "R6 acks seen", ack_err, 0);
    chk(scl && !sda_low, "R5 bus idle after", {scl, sda_low}, 2'b10);

    // R2 late start ignored, R11 done holds
    f0 = frames;
    pulse_start();
    repeat (600) @(negedge clk);
    chk(frames == f0 && starts == f0, "R2 start after done ignored", frames, f0);
    chk(done == 1'b1, "R11 done stays", done, 1);

    // session 2: missing acknowledge on address byte of transfer 3
    inject = 1;
    do_reset();
    @(negedge clk);
    chk(done == 1'b0 && ack_err == 1'b0, "R1 reset clears flags", {done, ack_err}, 0);
    pulse_start();
    // R2 start while busy ignored
    repeat (50) @(negedge clk);
    pulse_start();
    wait_done(ok);
    chk(ok, "R10 done after retry", ok, 1);
    repeat (20) @(negedge clk);
    chk(ack_err == 1'b1, "R10 error flag", ack_err, 1);
    chk(frames == 11, "R10 R2 transfer count", frames, 11);
    chk(fr_n[3] == 1 && fr_b[3][0] == 8'h34, "R10 refused transfer", fr_n[3], 1);
    for (int k = 0; k < 11; k++) begin
      int w;
      if (k == 3) continue;
      w = (k < 3) ? k : k - 1;
      chk({fr_b[k][0], fr_b[k][1], fr_b[k][2]} == VEC[w],
          "R10 retry order", {fr_b[k][0], fr_b[k][1], fr_b[k][2]}, VEC[w]);
    end
    chk(stops == 11, "R5 stop after refusal", stops, 11);

    if (hung) chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150001) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule